// File: doc/BRIEF.md
# Comparator Output Trigger Conditioner

This block sits between a digital comparator result and an ADC start input. It samples the comparator output on the system clock and watches it for the condition chosen by a control word. That condition is either a level of a chosen polarity, a falling transition, a rising transition, or a transition in either direction. Each time the condition is met, the block produces a trigger for the ADC.

Detection always runs. A separate forward-enable bit decides whether detected events reach the trigger output. Turning forwarding off therefore hides events without losing track of the comparator's history.

The same control word holds a two-bit positive-input source code. The block does not interpret this code. It presents it on an output so that an external analog multiplexer can select the comparator's positive input.

Software reaches the control word through a write strobe with a 32-bit data word. A 32-bit read word is always present on the read output.

Top module: `cmp_trig_cond`

## Requirements
- R1: After reset the read word is 0x00000000, the source output is 00 and the trigger output is 0. This means level mode, active-low polarity, forwarding off and source code 00.
- R2: A cycle with the write strobe high loads the writable fields from the data word. The new value appears on the read word after that clock edge. The writable fields are: forward enable at bit 11, source code at bits 10:9, level polarity at bit 7 and sense mode at bits 6:5.
- R3: Every other bit reads 0 whatever was written to it. This covers bits 31:12, bit 8 and bits 4:0.
- R4: The source output always equals read-word bits 10:9 (00 pin, 01 shared pin, 10 internal reference, 11 reserved).
- R5: In level mode (mode 00) with polarity 0 and forwarding on, the trigger output is high in every cycle the comparator input is low.
- R6: In level mode with polarity 1 and forwarding on, the trigger output is high in every cycle the comparator input is high.
- R7: In falling mode (01), a 1-to-0 change of the comparator input between consecutive clock samples gives a trigger exactly one cycle wide. A 0-to-1 change gives none.
- R8: In rising mode (10), a 0-to-1 change gives a trigger exactly one cycle wide. A 1-to-0 change gives none.
- R9: In either-edge mode (11), each change in either direction gives a trigger one cycle wide.
- R10: With forwarding off (bit 11 = 0) the trigger output stays 0. Detection still tracks the input, so a change seen while forwarding is off is not reported after forwarding is turned on.
- R11: The stored previous sample follows the comparator input while reset is held. A high input at reset release therefore gives no edge trigger.
- R12: A change of sense mode or polarity in itself produces no edge trigger while the comparator input is steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Single-cycle control write strobe |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control word, reserved bits zero |
| cmp_in | input | 1 | Synchronous comparator output |
| src_sel | output | 2 | Positive-input source code for the external mux |
| trig_out | output | 1 | ADC trigger event |

## Verification
The comparator input is driven through four patterns in each mode: steady low, steady high, a single rise and a single fall. Level mode must follow the input in every cycle. Each edge mode must fire once for its own direction only, which tells the three edge modes apart and separates edge from level behaviour.

Two further scenarios cover the hidden history. In one, the input toggles with forwarding off and forwarding is then turned on. In the other, the input is held high through reset release and mode changes are made with the input steady. Together they show that the previous-sample register keeps tracking the input without ever leaking a stale event.

// File: rtl/ctc_pkg.sv
// Package: shared field positions, mask and sense-mode encoding for the
// comparator trigger conditioner. Assumes a 32-bit control word.
package ctc_pkg;

    localparam int CTRL_W   = 32;
    localparam int EN_BIT   = 11;
    localparam int SRC_LO   = 9;
    localparam int SRC_W    = 2;
    localparam int POL_BIT  = 7;
    localparam int MODE_LO  = 5;
    localparam int MODE_W   = 2;

    // Bits that hold state; every other bit reads as zero.
    localparam logic [CTRL_W-1:0] WR_MASK =
        (CTRL_W'(1) << EN_BIT) |
        (CTRL_W'((1 << SRC_W) - 1) << SRC_LO) |
        (CTRL_W'(1) << POL_BIT) |
        (CTRL_W'((1 << MODE_W) - 1) << MODE_LO);

    typedef enum logic [MODE_W-1:0] {
        SENSE_LEVEL = 2'b00,
        SENSE_FALL  = 2'b01,
        SENSE_RISE  = 2'b10,
        SENSE_BOTH  = 2'b11
    } sense_e;

endpackage

// File: rtl/ctc_ctrl_reg.sv
// Control word register. Stores only the writable fields (mask applied on
// write) and decodes them. Assumes wr_en is a single-cycle strobe.
module ctc_ctrl_reg
    import ctc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    output logic              fwd_en,
    output logic [SRC_W-1:0]  src_code,
    output logic              lvl_pol,
    output sense_e            mode
);

    logic [CTRL_W-1:0] ctrl_q;

    // Load the masked write word; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= wr_data & WR_MASK;
        end
    end

    // Decode the stored word into its fields.
    always_comb begin
        rd_data  = ctrl_q;
        fwd_en   = ctrl_q[EN_BIT];
        src_code = ctrl_q[SRC_LO +: SRC_W];
        lvl_pol  = ctrl_q[POL_BIT];
        mode     = sense_e'(ctrl_q[MODE_LO +: MODE_W]);
    end

endmodule

// File: rtl/ctc_sense.sv
// Sense detector. Keeps the previous comparator sample and flags the event
// chosen by the mode. Assumes cmp_in is already synchronous to clk. The
// previous sample follows the input during reset, so no edge appears at
// reset release.
module ctc_sense
    import ctc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cmp_in,
    input  sense_e mode,
    input  logic   lvl_pol,
    output logic   det
);

    logic prev_q;
    logic rise;
    logic fall;

    // Track the last sample, also while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= cmp_in;
        end else begin
            prev_q <= cmp_in;
        end
    end

    // Select the event for the current mode.
    always_comb begin
        rise = cmp_in & ~prev_q;
        fall = ~cmp_in & prev_q;
        unique case (mode)
            SENSE_LEVEL: det = (cmp_in == lvl_pol);
            SENSE_FALL:  det = fall;
            SENSE_RISE:  det = rise;
            SENSE_BOTH:  det = rise | fall;
            default:     det = 1'b0;
        endcase
    end

endmodule

// File: rtl/ctc_gate.sv
// Forward gate. Passes a detected event to the trigger output only while
// forwarding is enabled. Pure combinational; assumes inputs are stable
// before the sampling edge.
module ctc_gate (
    input  logic det,
    input  logic fwd_en,
    output logic trig
);

    // Suppress events while forwarding is off.
    always_comb begin
        trig = det & fwd_en;
    end

endmodule

// File: rtl/cmp_trig_cond.sv
// Comparator output trigger conditioner top. Connects the control
// register, the sense detector and the forward gate. Assumes a synchronous
// comparator input and a synchronous active-low reset.
module cmp_trig_cond
    import ctc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    input  logic              cmp_in,
    output logic [SRC_W-1:0]  src_sel,
    output logic              trig_out
);

    logic   fwd_en;
    logic   lvl_pol;
    sense_e mode;
    logic   det;

    ctc_ctrl_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .fwd_en   (fwd_en),
        .src_code (src_sel),
        .lvl_pol  (lvl_pol),
        .mode     (mode)
    );

    ctc_sense u_sense (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmp_in  (cmp_in),
        .mode    (mode),
        .lvl_pol (lvl_pol),
        .det     (det)
    );

    ctc_gate u_gate (
        .det    (det),
        .fwd_en (fwd_en),
        .trig   (trig_out)
    );

endmodule

// File: rtl/ctc_checker.sv
// Property checker for cmp_trig_cond, attached by bind. Observes ports only.
module ctc_checker
    import ctc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [CTRL_W-1:0] wr_data,
    input logic [CTRL_W-1:0] rd_data,
    input logic              cmp_in,
    input logic [SRC_W-1:0]  src_sel,
    input logic              trig_out
);

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data == ($past(wr_data) & WR_MASK)); // R2

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~WR_MASK) == '0); // R3

    AST_SRC_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        src_sel == rd_data[SRC_LO +: SRC_W]); // R4

    AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[MODE_LO +: MODE_W] == SENSE_LEVEL && rd_data[EN_BIT])
        |-> trig_out == (cmp_in == rd_data[POL_BIT])); // R5

    AST_FALL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_out && rd_data[MODE_LO +: MODE_W] == SENSE_FALL)
        |=> (rd_data[MODE_LO +: MODE_W] != SENSE_FALL || !trig_out)); // R7

    AST_RISE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_out && rd_data[MODE_LO +: MODE_W] == SENSE_RISE)
        |=> (rd_data[MODE_LO +: MODE_W] != SENSE_RISE || !trig_out)); // R8

    AST_NO_TRIG_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[EN_BIT] |-> !trig_out); // R10

endmodule

bind cmp_trig_cond ctc_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .cmp_in   (cmp_in),
    .src_sel  (src_sel),
    .trig_out (trig_out)
);

// File: tb/cmp_trig_cond_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module cmp_trig_cond_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        cmp_in = 1'b0;
    logic [1:0]  src_sel;
    logic        trig_out;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    cmp_trig_cond u_cmp_trig_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .cmp_in   (cmp_in),
        .src_sel  (src_sel),
        .trig_out (trig_out)
    );

    function automatic logic [31:0] mk(input logic en, input logic [1:0] src,
                                       input logic pol, input logic [1:0] md);
        return {20'b0, en, src, 1'b0, pol, md, 5'b0};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Write at a falling edge; the value is visible after the next rising edge.
    task automatic write_ctrl(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
        #1;
    endtask

    // Drive the comparator at a falling edge and settle.
    task automatic drive_cmp(input logic v);
        @(negedge clk);
        cmp_in = v;
        #1;
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        #1;
    endtask

    task automatic do_reset(input logic cmp_level);
        @(negedge clk);
        rst_n = 1'b0;
        cmp_in = cmp_level;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic t_reset_state();
        do_reset(1'b0);
        chk("R1 rd_data", rd_data, 32'h0);
        chk("R1 src_sel", {30'b0, src_sel}, 32'h0);
        chk("R1 trig_out", {31'b0, trig_out}, 32'h0);
    endtask

    task automatic t_regs();
        write_ctrl(32'hFFFF_FFFF);
        chk("R2 all ones", rd_data, 32'h0000_0EE0);
        chk("R3 reserved zero", rd_data & 32'hFFFF_F11F, 32'h0);
        chk("R4 src 11", {30'b0, src_sel}, 32'h3);
        write_ctrl(32'hFFFF_F11F);
        chk("R3 reserved-only write", rd_data, 32'h0);
        write_ctrl(mk(1'b0, 2'b10, 1'b1, 2'b01));
        chk("R2 field load", rd_data, 32'h0000_04A0);
        chk("R4 src 10", {30'b0, src_sel}, 32'h2);
        write_ctrl(mk(1'b0, 2'b01, 1'b0, 2'b00));
        chk("R4 src 01", {30'b0, src_sel}, 32'h1);
    endtask

    task automatic t_level();
        write_ctrl(mk(1'b1, 2'b00, 1'b0, 2'b00));
        drive_cmp(1'b0);
        chk("R5 low active c1", {31'b0, trig_out}, 32'h1);
        idle_cycle();
        chk("R5 low active c2", {31'b0, trig_out}, 32'h1);
        drive_cmp(1'b1);
        chk("R5 high inactive", {31'b0, trig_out}, 32'h0);
        write_ctrl(mk(1'b1, 2'b00, 1'b1, 2'b00));
        chk("R6 high active c1", {31'b0, trig_out}, 32'h1);
        idle_cycle();
        chk("R6 high active c2", {31'b0, trig_out}, 32'h1);
        drive_cmp(1'b0);
        chk("R6 low inactive", {31'b0, trig_out}, 32'h0);
    endtask

    task automatic t_falling();
        drive_cmp(1'b1);
        write_ctrl(mk(1'b1, 2'b00, 1'b0, 2'b01));
        chk("R7 steady high", {31'b0, trig_out}, 32'h0);
        drive_cmp(1'b0);
        chk("R7 fall pulse", {31'b0, trig_out}, 32'h1);
        idle_cycle();
        chk("R7 pulse one wide", {31'b0, trig_out}, 32'h0);
        drive_cmp(1'b1);
        chk("R7 rise ignored", {31'b0, trig_out}, 32'h0);
    endtask

    task automatic t_rising();
        drive_cmp(1'b0);
        write_ctrl(mk(1'b1, 2'b00, 1'b0, 2'b10));
        chk("R8 steady low", {31'b0, trig_out}, 32'h0);
        drive_cmp(1'b1);
        chk("R8 rise pulse", {31'b0, trig_out}, 32'h1);
        idle_cycle();
        chk("R8 pulse one wide", {31'b0, trig_out}, 32'h0);
        drive_cmp(1'b0);
        chk("R8 fall ignored", {31'b0, trig_out}, 32'h0);
    endtask

    task automatic t_both();
        write_ctrl(mk(1'b1, 2'b00, 1'b0, 2'b11));
        drive_cmp(1'b1);
        chk("R9 rise pulse", {31'b0, trig_out}, 32'h1);
        idle_cycle();
        chk("R9 rise one wide", {31'b0, trig_out}, 32'h0);
        drive_cmp(1'b0);
        chk("R9 fall pulse", {31'b0, trig_out}, 32'h1);
        idle_cycle();
        chk("R9 fall one wide", {31'b0, trig_out}, 32'h0);
    endtask

    task automatic t_disable();
        write_ctrl(mk(1'b0, 2'b00, 1'b0, 2'b10));
        drive_cmp(1'b1);
        chk("R10 rise suppressed", {31'b0, trig_out}, 32'h0);
        write_ctrl(mk(1'b1, 2'b00, 1'b0, 2'b10));
        chk("R10 no stale event", {31'b0, trig_out}, 32'h0);
        drive_cmp(1'b0);
        drive_cmp(1'b1);
        chk("R10 later rise forwarded", {31'b0, trig_out}, 32'h1);
        write_ctrl(mk(1'b0, 2'b00, 1'b0, 2'b00));
        drive_cmp(1'b0);
        chk("R10 level suppressed", {31'b0, trig_out}, 32'h0);
    endtask

    task automatic t_reset_release_high();
        do_reset(1'b1);
        write_ctrl(mk(1'b1, 2'b00, 1'b0, 2'b10));
        chk("R11 no edge after reset", {31'b0, trig_out}, 32'h0);
        write_ctrl(mk(1'b1, 2'b00, 1'b0, 2'b11));
        chk("R11 either mode quiet", {31'b0, trig_out}, 32'h0);
    endtask

    task automatic t_mode_change();
        drive_cmp(1'b1);
        write_ctrl(mk(1'b1, 2'b00, 1'b0, 2'b01));
        chk("R12 to falling quiet", {31'b0, trig_out}, 32'h0);
        write_ctrl(mk(1'b1, 2'b00, 1'b1, 2'b10));
        chk("R12 to rising quiet", {31'b0, trig_out}, 32'h0);
        idle_cycle();
        chk("R12 still quiet", {31'b0, trig_out}, 32'h0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        t_reset_state();
        t_regs();
        t_level();
        t_falling();
        t_rising();
        t_both();
        t_disable();
        t_reset_release_high();
        t_mode_change();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule